// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

The block is a timer peripheral with three independent 32-bit down counters. Each channel holds a live count, a reload value and a small control word made of an underflow flag and an interrupt enable. A shared start register decides which channels run. A running channel decrements on every cycle in which the external count strobe `cnt_tick` is high. When a counter that already reads zero is decremented, it reloads from its reload register and raises its underflow flag. Channel 2 also has an input-capture path: a rising edge on `cap_in` copies that channel's count into a capture register and raises a capture flag.

Software reaches every register through a simple synchronous bus. Writes take effect at the clock edge. Read data appears on `bus_rdata` one cycle after `bus_rd` and shows the register contents of the cycle in which the read was issued. The four interrupt sources are the three underflows and the capture. They are merged into one request line and a 2-bit code that names the most urgent pending source.

Register addresses (4-bit): 0 start; channel n count at 1+3n, reload at 2+3n, control at 3+3n; 10 capture value (read only); 11 capture control. In both kinds of control word, bit 0 is the flag and bit 1 is the interrupt enable.

Top module: `tmr3_unit`

## Requirements
- R1: After reset, the start register reads 0. Every count and reload register reads 0xFFFFFFFF. Every control word and the capture value read 0. `irq` is 0 and `irq_code` is 0.
- R2: Bits 0, 1 and 2 of the start register (address 0) enable channels 0, 1 and 2. An enabled channel's count drops by exactly 1 on each clock edge where `cnt_tick` is 1. A channel whose start bit is 0, or that sees no tick, keeps its count.
- R3: When a channel is decremented while its count is 0, its count takes the reload value at that edge and its control bit 0 becomes 1.
- R4: A write to a channel's count or reload register lands only while that channel's start bit is 0. While the start bit is 1, such a write leaves the register unchanged.
- R5: A control word write sets bit 1 (enable) to the written value. Writing 0 to bit 0 clears the flag and writing 1 leaves it unchanged. When an underflow or capture occurs in the same cycle as a clearing write, the flag ends at 1.
- R6: `bus_rdata` in the cycle after a read shows the register as it stood when `bus_rd` was sampled. A count read in the same cycle as a decrement returns the value from before that decrement.
- R7: A 0-to-1 change of `cap_in` copies channel 2's count from that cycle into the capture register (address 10) and sets capture control bit 0 (address 11). Holding `cap_in` high captures nothing more.
- R8: `irq` is 1 exactly when some source has both its flag and its enable at 1. `irq_code` then names the highest-ranked such source, from first to last: 0 = channel 0 underflow, 1 = channel 1 underflow, 2 = channel 2 underflow, 3 = capture. `irq_code` is 0 while `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| cnt_tick | input | 1 | Count strobe shared by all running channels |
| cap_in | input | 1 | Capture trigger for channel 2, rising edge |
| irq | output | 1 | Combined interrupt request |
| irq_code | output | 2 | Code of the highest-ranked pending source |

## Verification
The bench builds the block with its defaults: 32-bit counters and an all-ones reset value. Because of that reset value, a channel started without programming would take about four billion ticks to underflow, so every underflow the bench exercises comes from a count written to zero or near zero. The bench drives `cnt_tick` one edge at a time. This lets it line up a decrement exactly with a read, with a clearing write, or with a capture edge. Those collision cases are the ones R5, R6 and R7 depend on.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;

    // register layout
    localparam int REG_START  = 0;
    localparam int CH_BASE    = 1;
    localparam int CH_STRIDE  = 3;
    localparam int OFS_CNT    = 0;
    localparam int OFS_RLD    = 1;
    localparam int OFS_CTL    = 2;
    localparam int REG_CAPVAL = 10;
    localparam int REG_CAPCTL = 11;

    // control word bit positions
    localparam int CTL_FLAG = 0;
    localparam int CTL_IEN  = 1;

    // interrupt source ranking, lowest code is most urgent
    typedef enum logic [1:0] {
        SRC_UF0 = 2'd0,
        SRC_UF1 = 2'd1,
        SRC_UF2 = 2'd2,
        SRC_CAP = 2'd3
    } tmr3_src_e;

endpackage

// File: rtl/tmr3_chan.sv
module tmr3_chan
    import tmr3_pkg::*;
#(
    parameter int                CNT_W    = 32,
    parameter logic [CNT_W-1:0]  CNT_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             flag_o,
    output logic             ien_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             flag;
        logic             ien;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     dec;
    logic     uflow;

    always_comb begin
        s_d   = s_q;
        dec   = run & tick;
        uflow = dec && (s_q.cnt == '0);

        if (dec) begin
            s_d.cnt = uflow ? s_q.rld : s_q.cnt - 1'b1;
        end else if (wr_cnt && !run) begin
            s_d.cnt = wdata;
        end

        if (wr_rld && !run) begin
            s_d.rld = wdata;
        end

        if (wr_ctl) begin
            s_d.ien = wdata[CTL_IEN];
            if (!wdata[CTL_FLAG]) begin
                s_d.flag = 1'b0;
            end
        end

        if (uflow) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_INIT;
            s_q.rld  <= CNT_INIT;
            s_q.flag <= 1'b0;
            s_q.ien  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign rld_o  = s_q.rld;
    assign flag_o = s_q.flag;
    assign ien_o  = s_q.ien;

    AST_DECREMENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1)); // R2

    AST_RUNNING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(s_q.cnt) && $stable(s_q.rld))); // R4

    AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && s_q.cnt == '0) |=> (s_q.cnt == $past(s_q.rld) && s_q.flag)); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && wr_ctl) |=> s_q.flag); // R5

endmodule

// File: rtl/tmr3_capture.sv
module tmr3_capture
    import tmr3_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt_src,
    input  logic             wr_ctl,
    input  logic [1:0]       ctl_wdata,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o,
    output logic             ien_o
);

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             prev;
        logic             flag;
        logic             ien;
    } cap_st_t;

    cap_st_t s_d, s_q;
    logic    rise;

    always_comb begin
        s_d      = s_q;
        rise     = cap_in & ~s_q.prev;
        s_d.prev = cap_in;

        if (rise) begin
            s_d.val = cnt_src;
        end

        if (wr_ctl) begin
            s_d.ien = ctl_wdata[CTL_IEN];
            if (!ctl_wdata[CTL_FLAG]) begin
                s_d.flag = 1'b0;
            end
        end

        if (rise) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_o  = s_q.val;
    assign flag_o = s_q.flag;
    assign ien_o  = s_q.ien;

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (s_q.flag && s_q.val == $past(cnt_src))); // R7

    AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(s_q.val)); // R7

endmodule

// File: rtl/tmr3_prio.sv
module tmr3_prio #(
    parameter int NSRC = 4,
    localparam int CODE_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend,
    output logic              req,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        req  = 1'b0;
        code = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                req  = 1'b1;
                code = CODE_W'(i);
            end
        end
    end

    AST_CODE_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> pend[code]); // R8

    AST_NOTHING_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((pend & ((NSRC'(1) << code) - NSRC'(1))) == '0)); // R8

    AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!req && code == '0)); // R8

endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit
    import tmr3_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter int               ADDR_W   = 4,
    parameter logic [CNT_W-1:0] CNT_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cnt_tick,
    input  logic              cap_in,
    output logic              irq,
    output logic [1:0]        irq_code
);

    localparam int NCH    = 3;
    localparam int NSRC   = NCH + 1;
    localparam int CODE_W = $clog2(NSRC);
    localparam int CAP_CH = NCH - 1;

    typedef struct packed {
        logic [NCH-1:0]   start;
        logic [CNT_W-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [CNT_W-1:0] ch_cnt [NCH];
    logic [CNT_W-1:0] ch_rld [NCH];
    logic [NCH-1:0]   ch_flag, ch_ien;
    logic [NCH-1:0]   wr_cnt, wr_rld, wr_ctl;

    logic [CNT_W-1:0] cap_val;
    logic             cap_flag, cap_ien, wr_capctl;

    logic [NSRC-1:0]   pend;
    logic [CODE_W-1:0] code;
    logic              req;

    // per-channel counters
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int BASE = CH_BASE + g * CH_STRIDE;

        assign wr_cnt[g] = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_CNT));
        assign wr_rld[g] = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_RLD));
        assign wr_ctl[g] = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_CTL));

        tmr3_chan #(
            .CNT_W    (CNT_W),
            .CNT_INIT (CNT_INIT)
        ) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (s_q.start[g]),
            .tick   (cnt_tick),
            .wr_cnt (wr_cnt[g]),
            .wr_rld (wr_rld[g]),
            .wr_ctl (wr_ctl[g]),
            .wdata  (bus_wdata),
            .cnt_o  (ch_cnt[g]),
            .rld_o  (ch_rld[g]),
            .flag_o (ch_flag[g]),
            .ien_o  (ch_ien[g])
        );
    end

    // input capture on the last channel
    assign wr_capctl = bus_wr && (bus_addr == ADDR_W'(REG_CAPCTL));

    tmr3_capture #(
        .CNT_W (CNT_W)
    ) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .cnt_src   (ch_cnt[CAP_CH]),
        .wr_ctl    (wr_capctl),
        .ctl_wdata (bus_wdata[1:0]),
        .cap_o     (cap_val),
        .flag_o    (cap_flag),
        .ien_o     (cap_ien)
    );

    // interrupt merge, bit index equals rank
    assign pend = {cap_flag & cap_ien, ch_flag & ch_ien};

    tmr3_prio #(
        .NSRC (NSRC)
    ) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .req   (req),
        .code  (code)
    );

    assign irq      = req;
    assign irq_code = code;

    // start register and read path
    always_comb begin
        logic [CNT_W-1:0] mux;

        s_d = s_q;
        mux = '0;

        if (bus_wr && bus_addr == ADDR_W'(REG_START)) begin
            s_d.start = bus_wdata[NCH-1:0];
        end

        if (bus_addr == ADDR_W'(REG_START)) begin
            mux = CNT_W'(s_q.start);
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_CNT)) begin
                mux = ch_cnt[i];
            end
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_RLD)) begin
                mux = ch_rld[i];
            end
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_CTL)) begin
                mux = {{(CNT_W-2){1'b0}}, ch_ien[i], ch_flag[i]};
            end
        end
        if (bus_addr == ADDR_W'(REG_CAPVAL)) begin
            mux = cap_val;
        end
        if (bus_addr == ADDR_W'(REG_CAPCTL)) begin
            mux = {{(CNT_W-2){1'b0}}, cap_ien, cap_flag};
        end

        if (bus_rd) begin
            s_d.rdata = mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;

    AST_STOPPED_CH0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.start[0] && !wr_cnt[0]) |=> $stable(ch_cnt[0])); // R2

    AST_READ_PRE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(CH_BASE + OFS_CNT)) |=> (bus_rdata == $past(ch_cnt[0]))); // R6

endmodule

// File: tb/test_tmr3_unit.sv
module test_tmr3_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [3:0] A_START = 4'd0;
    localparam logic [3:0] A_CNT0  = 4'd1;
    localparam logic [3:0] A_RLD0  = 4'd2;
    localparam logic [3:0] A_CTL0  = 4'd3;
    localparam logic [3:0] A_CNT1  = 4'd4;
    localparam logic [3:0] A_RLD1  = 4'd5;
    localparam logic [3:0] A_CTL1  = 4'd6;
    localparam logic [3:0] A_CNT2  = 4'd7;
    localparam logic [3:0] A_CTL2  = 4'd9;
    localparam logic [3:0] A_CAP   = 4'd10;
    localparam logic [3:0] A_CAPC  = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        cnt_tick = 1'b0;
    logic        cap_in = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [1:0]  irq_code;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic rd_d = 1'b0;
    logic done = 1'b0;

    tmr3_unit i_tmr3_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .cap_in    (cap_in),
        .irq       (irq),
        .irq_code  (irq_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) rd_d <= bus_rd;

    // monitor: pops one expected read item per returned read
    always @(negedge clk) begin
        if (rd_d) begin
            exp_t e;
            n_run++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=<none>", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.v) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, bus_rdata, e.v);
                end
            end
        end
    end

    // one bus cycle; driving happens just after the rising edge
    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic t,
                       input logic [31:0] ev, input string tag);
        exp_t e;
        bus_wr    = w;
        bus_rd    = r;
        bus_addr  = a;
        bus_wdata = d;
        cnt_tick  = t;
        if (r) begin
            e.v   = ev;
            e.tag = tag;
            sbq.push_back(e);
        end
        @(posedge clk);
        #1;
        bus_wr   = 1'b0;
        bus_rd   = 1'b0;
        cnt_tick = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] ev, input string tag);
        cyc(1'b0, 1'b1, a, '0, 1'b0, ev, tag);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'd0, '0, 1'b1, '0, "");
    endtask

    task automatic chk_irq(input logic ei, input logic [1:0] ec, input string tag);
        @(negedge clk);
        n_run++;
        if (irq !== ei || irq_code !== ec) begin
            n_fail++;
            $display("FAIL %s actual irq=%b code=%0d expected irq=%b code=%0d",
                     tag, irq, irq_code, ei, ec);
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        rd(A_START, 32'h0, "R1 start");
        rd(A_CNT0, 32'hFFFF_FFFF, "R1 count");
        rd(A_RLD0, 32'hFFFF_FFFF, "R1 reload");
        rd(A_CTL0, 32'h0, "R1 control");
        rd(A_CAP, 32'h0, "R1 capture");
        chk_irq(1'b0, 2'd0, "R1 irq");

        // R4 writes to a stopped channel land
        wr(A_CNT0, 32'd5);
        wr(A_RLD0, 32'd9);
        rd(A_CNT0, 32'd5, "R4 stopped count write");
        rd(A_RLD0, 32'd9, "R4 stopped reload write");

        // R2 start without tick holds; R4 running writes ignored
        wr(A_START, 32'd1);
        rd(A_CNT0, 32'd5, "R2 no tick");
        wr(A_CNT0, 32'd100);
        wr(A_RLD0, 32'd77);
        rd(A_CNT0, 32'd5, "R4 running count write");
        rd(A_RLD0, 32'd9, "R4 running reload write");

        // R2 counting
        tk(3);
        rd(A_CNT0, 32'd2, "R2 three ticks");
        rd(A_CNT1, 32'hFFFF_FFFF, "R2 stopped channel");

        // R6 read collides with decrement
        cyc(1'b0, 1'b1, A_CNT0, '0, 1'b1, 32'd2, "R6 pre-decrement read");
        rd(A_CNT0, 32'd1, "R6 after decrement");

        // R3 underflow reload
        tk(2);
        rd(A_CNT0, 32'd9, "R3 reload");
        rd(A_CTL0, 32'd1, "R3 flag");
        chk_irq(1'b0, 2'd0, "R8 masked");

        // R5 enable, flag kept by writing 1
        wr(A_CTL0, 32'd3);
        chk_irq(1'b1, 2'd0, "R8 ch0");
        rd(A_CTL0, 32'd3, "R5 write 1 keeps");

        // R8 two pending sources
        wr(A_CNT1, 32'd0);
        wr(A_RLD1, 32'd3);
        wr(A_CTL1, 32'd2);
        wr(A_START, 32'd3);
        tk(1);
        chk_irq(1'b1, 2'd0, "R8 ch0 over ch1");
        wr(A_CTL0, 32'd2);
        chk_irq(1'b1, 2'd1, "R8 ch1 alone");
        rd(A_CTL0, 32'd2, "R5 clear");
        rd(A_CNT1, 32'd3, "R3 ch1 reload");

        // R5 set beats clear
        wr(A_START, 32'd0);
        wr(A_CNT1, 32'd0);
        wr(A_CTL1, 32'd2);
        chk_irq(1'b0, 2'd0, "R5 clear drops irq");
        wr(A_START, 32'd2);
        cyc(1'b1, 1'b0, A_CTL1, 32'd2, 1'b1, '0, "");
        rd(A_CTL1, 32'd3, "R5 set wins");
        chk_irq(1'b1, 2'd1, "R5 irq after set");
        wr(A_RLD1, 32'd44);
        rd(A_RLD1, 32'd3, "R4 ch1 reload ignored");

        // R7 capture
        wr(A_START, 32'd0);
        wr(A_CNT2, 32'd50);
        wr(A_START, 32'd4);
        tk(3);
        cap_in = 1'b1;
        tk(1);
        rd(A_CAP, 32'd47, "R7 captured value");
        rd(A_CAPC, 32'd1, "R7 capture flag");
        tk(2);
        rd(A_CAP, 32'd47, "R7 held level no capture");
        rd(A_CNT2, 32'd44, "R2 ch2 count");
        chk_irq(1'b1, 2'd1, "R8 capture masked");
        wr(A_CAPC, 32'd3);
        chk_irq(1'b1, 2'd1, "R8 ch1 over capture");
        wr(A_CTL1, 32'd0);
        chk_irq(1'b1, 2'd3, "R8 capture alone");

        // R8 ch2 underflow outranks capture
        wr(A_START, 32'd0);
        wr(A_CNT2, 32'd0);
        wr(A_CTL2, 32'd2);
        wr(A_START, 32'd4);
        tk(1);
        chk_irq(1'b1, 2'd2, "R8 ch2 over capture");
        rd(A_CNT2, 32'hFFFF_FFFF, "R3 ch2 reload");

        // R7 new edge captures again
        cap_in = 1'b0;
        tk(0);
        cyc(1'b0, 1'b0, 4'd0, '0, 1'b0, '0, "");
        cap_in = 1'b1;
        cyc(1'b0, 1'b0, 4'd0, '0, 1'b0, '0, "");
        rd(A_CAP, 32'hFFFF_FFFF, "R7 second edge");

        repeat (3) @(posedge clk);
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule